// File: doc/BRIEF.md
# Serial EEPROM Word Read Sequencer

This block fetches one 16-bit word from a three-wire serial EEPROM (Microwire-style: select, clock, data-in, data-out). A single-cycle request carrying an 8-bit word address starts the transfer. The block then walks a fixed list of pin states. Each state is held on a small control word for a programmable number of system clock cycles, so the serial clock runs far slower than the system clock and every transition settles before the next one.

The list opens with one dummy serial clock. Then come a start bit, the two-bit read opcode and the address, most significant bit first. Sixteen data bits follow, each clocked out of the device and sampled after the falling clock step. A fixed teardown ends the list. When the last step has settled, the assembled word is written to the result register and done pulses for one cycle. Only reads are supported. A start request that arrives during a transfer is dropped.

Top module: `eeprom_rd`

## Requirements
- R1: `ctl_o` carries the pin states: bit 0 is the serial clock, bit 1 is the chip select and bit 2 is the data-in line. `dq_i` is the device data-out line. While busy, data-in is never high unless select is also high.
- R2: A transfer opens with four steps: all low, select, select with clock, select. This gives one dummy clock before the start bit.
- R3: The start bit and the read opcode (1 then 0) take six steps: select+data, select+data+clock, select+data, select+data+clock, select, select+clock.
- R4: The 8 address bits go out most significant bit first. Each bit takes two steps: select with data-in equal to the bit, then the same with clock high. One select-only step follows the last bit.
- R5: Sixteen data bits are read, most significant bit first. Each bit takes two steps: select+clock, then select. `dq_i` is sampled at the end of the select step.
- R6: Teardown is four steps: all low, select, all low, clock. `ctl_o` keeps the clock-only value while the block is idle.
- R7: Every step holds `ctl_o` for exactly `SETTLE_CYCLES` system clocks. A transfer of 63 steps therefore lasts 63*`SETTLE_CYCLES` cycles.
- R8: `busy_o` rises in the cycle after a start is accepted. `busy_o` falls in the same cycle that `done_o` is high, and `done_o` is high for one cycle only.
- R9: `start_i` is ignored while `busy_o` is high. This includes the final cycle of a transfer.
- R10: `data_o` changes only in the cycle where `done_o` is high, and then holds the word that was read.
- R11: After reset, `ctl_o`, `busy_o`, `done_o` and `data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read request, accepted when idle |
| addr_i | input | 8 | Word address, captured at accept |
| dq_i | input | 1 | Serial data from the EEPROM |
| ctl_o | output | 3 | Pin control word {data-in, select, clock} |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 16 | Last word read |

## Verification
A transfer can finish in the same cycle that a new request arrives. In that cycle `busy_o` is still high, so the request must be dropped, and it is accepted one cycle later when the block is idle. The bench raises `start_i` with a second address during the final settle cycle of a read and keeps it high. It then checks three things: the first read completes with its own word, no extra steps are inserted, and the next transfer starts exactly one cycle after done and carries the second address to the EEPROM model. A request that arrives in the middle of a transfer is also checked: the address the model receives and the step sequence must not change.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int HDR_STEPS = 10;                       // open + start + opcode
  localparam int ADDR_END  = HDR_STEPS + 2 * ADDR_W;   // select-only step index
  localparam int DATA_END  = ADDR_END + 1 + 2 * DATA_W;
  localparam int NUM_STEPS = DATA_END + 4;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef logic [2:0] ctl_t;
  localparam ctl_t C_CLK = 3'b001;
  localparam ctl_t C_SEL = 3'b010;
  localparam ctl_t C_DIN = 3'b100;

  function automatic ctl_t step_word(input int idx, input logic [ADDR_W-1:0] addr);
    ctl_t w;
    int   k;
    w = '0;
    if (idx < HDR_STEPS) begin
      case (idx)
        1, 3, 8: w = C_SEL;
        2, 9:    w = C_SEL | C_CLK;
        4, 6:    w = C_SEL | C_DIN;
        5, 7:    w = C_SEL | C_DIN | C_CLK;
        default: w = '0;
      endcase
    end else if (idx < ADDR_END) begin
      k = idx - HDR_STEPS;
      w = C_SEL;
      if (addr[ADDR_W - 1 - k / 2]) w = w | C_DIN;
      if (k % 2 == 1) w = w | C_CLK;
    end else if (idx == ADDR_END) begin
      w = C_SEL;
    end else if (idx < DATA_END) begin
      k = idx - ADDR_END - 1;
      w = (k % 2 == 1) ? C_SEL : (C_SEL | C_CLK);
    end else begin
      case (idx - DATA_END)
        1:       w = C_SEL;
        3:       w = C_CLK;
        default: w = '0;
      endcase
    end
    return w;
  endfunction

  function automatic logic is_sample(input int idx);
    return (idx > ADDR_END) && (idx < DATA_END) && ((idx - ADDR_END - 1) % 2 == 1);
  endfunction
endpackage

// File: rtl/eeprom_rd_timer.sv
module eeprom_rd_timer #(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(SETTLE_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eeprom_rd_shift.sv
module eeprom_rd_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] value_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      value_o <= '0;
    else if (shift_i) value_o <= {value_o[WIDTH-2:0], bit_i};
  end
endmodule

// File: rtl/eeprom_rd.sv
module eeprom_rd
  import eeprom_rd_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dq_i,
  output logic [2:0]        ctl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] addr_q;
  logic              expire;
  logic              accept;
  logic              sample;
  logic [DATA_W-1:0] shreg;

  assign accept = !busy_o && start_i;
  assign sample = expire && is_sample(int'(step_q));

  eeprom_rd_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .restart_i (accept || expire),
    .expire_o  (expire)
  );

  eeprom_rd_shift #(.WIDTH(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sample),
    .bit_i   (dq_i),
    .value_o (shreg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_q <= '0;
      addr_q <= '0;
      ctl_o  <= '0;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_o <= 1'b1;
        step_q <= '0;
        addr_q <= addr_i;
        ctl_o  <= step_word(0, addr_i);
      end else if (expire) begin
        if (step_q == LAST_STEP) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          data_o <= shreg;
        end else begin
          step_q <= step_q + 1'b1;
          ctl_o  <= step_word(int'(step_q) + 1, addr_q);
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_rd_chk.sv
module eeprom_rd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [2:0]  ctl_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] data_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  p_start_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o));
  p_idle_ctl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(ctl_o));
  p_din_needs_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctl_o[2]) |-> ctl_o[1]);
endmodule

bind eeprom_rd eeprom_rd_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ctl_o   (ctl_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .data_o  (data_o)
);

// File: tb/eeprom_rd_tb.sv
module eeprom_rd_tb;
  localparam int SETTLE = 3;
  localparam int NSTEP  = 63;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0;
  logic [7:0]  addr_i = '0;
  logic        dq = 0;
  logic [2:0]  ctl_o;
  logic        busy_o, done_o;
  logic [15:0] data_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] last_word = '0;

  always #2 clk = ~clk;

  eeprom_rd #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .addr_i(addr_i), .dq_i(dq),
    .ctl_o(ctl_o), .busy_o(busy_o), .done_o(done_o), .data_o(data_o));

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {~a, a ^ 8'h5a} ^ {8'h00, a[3:0], a[7:4]};
  endfunction

  // behavioural EEPROM: bit 0 clock, bit 1 select, bit 2 data-in
  int          m_phase = 0, m_cnt = 0;
  logic [9:0]  m_shift = '0;
  logic [15:0] m_word = '0;
  logic [1:0]  m_op = '0;
  logic [7:0]  m_addr = '0;
  always @(negedge ctl_o[1]) begin m_phase = 0; m_cnt = 0; dq = 0; end
  always @(posedge ctl_o[0]) begin
    if (ctl_o[1]) begin
      if (m_phase == 0) begin
        if (ctl_o[2]) begin m_phase = 1; m_cnt = 0; end
      end else if (m_phase == 1) begin
        m_shift = {m_shift[8:0], ctl_o[2]};
        m_cnt++;
        if (m_cnt == 10) begin
          m_op = m_shift[9:8]; m_addr = m_shift[7:0];
          m_word = mem_word(m_shift[7:0]); m_phase = 2; m_cnt = 0;
        end
      end else if (m_cnt < 16) begin
        dq = m_word[15 - m_cnt];
        m_cnt++;
      end
    end
  end

  function automatic logic [2:0] exp_ctl(input int i, input logic [7:0] a);
    logic [2:0] hdr [10];
    hdr = '{3'b000, 3'b010, 3'b011, 3'b010, 3'b110, 3'b111, 3'b110, 3'b111, 3'b010, 3'b011};
    if (i < 10) return hdr[i];
    if (i < 26) return {a[7 - (i - 10) / 2], 1'b1, (i % 2) == 1};
    if (i == 26) return 3'b010;
    if (i < 59) return ((i - 27) % 2 == 0) ? 3'b011 : 3'b010;
    case (i)
      60: return 3'b010;
      62: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts at a negedge; ends at the negedge where done_o should be high
  task automatic run_read(input logic [7:0] a, input bit pre, input bit poke,
                          input bit chain, input logic [7:0] nxt);
    int e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0, e8 = 0, e10 = 0;
    if (!pre) begin start_i = 1; addr_i = a; end
    for (int i = 0; i < NSTEP; i++) begin
      for (int s = 0; s < SETTLE; s++) begin
        @(negedge clk);
        if (i == 0 && s == 0) start_i = 0;
        if (poke && i == 20 && s == 0) begin start_i = 1; addr_i = ~a; end
        if (poke && i == 20 && s == 1) start_i = 0;
        if (chain && i == NSTEP - 1 && s == SETTLE - 1) begin start_i = 1; addr_i = nxt; end
        if (ctl_o !== exp_ctl(i, a)) begin
          if (i < 4) e2++; else if (i < 10) e3++; else if (i < 27) e4++;
          else if (i < 59) e5++; else e6++;
        end
        if (!busy_o || done_o) e8++;
        if (data_o !== last_word) e10++;
      end
    end
    check(e2 == 0, "R2/R7 opening steps", e2, 0);
    check(e3 == 0, "R3/R7 start+opcode steps", e3, 0);
    check(e4 == 0, "R4/R7 address steps", e4, 0);
    check(e5 == 0, "R5/R7 data steps", e5, 0);
    check(e6 == 0, "R6/R7 teardown steps", e6, 0);
    check(e8 == 0, "R8 busy high, done low during transfer", e8, 0);
    check(e10 == 0, "R10 data_o held during transfer", e10, 0);
    check(m_op == 2'b10, "R3 opcode seen by device", m_op, 2);
    check(m_addr == a, "R4/R9 address seen by device", m_addr, a);
    @(negedge clk);
    check(done_o && !busy_o, "R8 done with busy low", {done_o, busy_o}, 2);
    check(data_o == mem_word(a), "R5/R10 word read", data_o, mem_word(a));
    check(ctl_o == 3'b001, "R6 final clock-only", ctl_o, 1);
    last_word = mem_word(a);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    check(ctl_o == 0 && !busy_o && !done_o && data_o == 0, "R11 reset state",
          {ctl_o, busy_o, done_o, data_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ctl_o == 0 && !busy_o, "R11 idle after reset", {ctl_o, busy_o}, 0);
    run_read(8'h00, 0, 0, 0, 8'h00);
    @(negedge clk);
    check(!done_o, "R8 done single cycle", done_o, 0);
    check(ctl_o[2] == 0 && ctl_o[1] == 0, "R1 select/data low idle", ctl_o, 1);
    run_read(8'hFF, 0, 1, 0, 8'h00);  // R9 mid-transfer request
    run_read(8'h80, 0, 0, 0, 8'h00);  // back-to-back from done cycle
    run_read(8'h01, 0, 0, 1, 8'h3c);  // R9 request at final cycle
    check(busy_o == 0, "R9 request in done cycle not taken", busy_o, 0);
    run_read(8'h3c, 1, 0, 0, 8'h00);
    for (int r = 0; r < 20; r++) begin
      logic [7:0] a;
      a = 8'($urandom());
      repeat ($urandom_range(0, 3)) @(negedge clk);
      run_read(a, 0, ($urandom() % 4) == 0, 0, 8'h00);
    end
    repeat (5) @(negedge clk);
    check(data_o == last_word && !busy_o, "R10 data held while idle", data_o, last_word);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule